// File: doc/BRIEF.md
# PCI Type 0 Configuration Address Translator

This block sits behind a CPU-side window that is set aside for configuration accesses to devices on the local PCI bus. Each access arrives with a 16-bit local offset, an access size of one, two or four bytes, a direction and write data. The block combines the offset with the upper half of a 32-bit mapping word held elsewhere on the chip. It then turns the result into a Type 0 configuration address and hands a single cycle request to the bus engine, which acknowledges it.

The device number is not a binary field. The combined word carries a one-hot select field in bits 31 to 11, and the device number is the index of its lowest set bit. A blocking bit in the mapping word suppresses all cycles: writes vanish, and reads return all ones at the access width. Malformed accesses, whether misaligned, of an illegal size or with an empty select field, end in an error response and issue no cycle. Every forwarded access also pulses a strobe that tells the bridge to clear its received-abort status bits.

Each accepted request produces exactly one response pulse. A forwarded access responds on the cycle after the bus engine acknowledges it. A suppressed or rejected access responds on the cycle after it is accepted.

Top module: `cfgx_translator`

## Requirements
- R1: After reset, `req_ready` is 1 and `cyc_valid`, `rsp_valid`, `rsp_err` and `clr_abort` are 0.
- R2: A forwarded cycle has `cyc_addr` = 0x80000000 | bus<<16 | dev<<11 | func<<8 | reg<<2. Here func is local address bits [10:8], reg is local address bits [7:2], and `cyc_addr[1:0]` is 0. Bit 31 is the configuration-enable flag.
- R3: The select field is bits [31:11] of the word {map_cfg[15:0], req_addr[15:0]}. The device number is the index of its lowest set bit, with index 0 at word bit 11.
- R4: `cyc_size`, `cyc_write` and `cyc_wdata` repeat the request's size, direction and data. Size codes are 0 for a byte, 1 for a halfword and 2 for a word. Code 3 is illegal.
- R5: While `cyc_valid` is high and `cyc_ready` is low, the cycle fields stay unchanged and `req_ready` is 0.
- R6: One cycle after the clock edge that sees `cyc_valid` and `cyc_ready` both high, `rsp_valid` is 1 for one cycle. For a read, `rsp_rdata` equals the `cyc_rdata` sampled at that edge. For a write, it is 0.
- R7: `clr_abort` is 1 exactly in the response cycle of a forwarded access and never for a suppressed or rejected one.
- R8: When `map_cfg[16]` is 1, no cycle is issued and the response follows acceptance by one cycle with `rsp_err` 0. `rsp_rdata` is 0xFF, 0xFFFF or 0xFFFFFFFF by size on reads, and 0 on writes.
- R9: An all-zero select field gives no cycle and a response with `rsp_err` 1. `rsp_rdata` is all ones at the access width on reads and 0 on writes.
- R10: A halfword with address bit 0 set, a word with address bits [1:0] nonzero, or size code 3 gives no cycle and a response with `rsp_err` 1. `rsp_rdata` is all ones at the width on reads, using 0xFFFFFFFF for code 3, and 0 on writes. This check takes precedence over R8, and R8 takes precedence over R9.
- R11: Every accepted request yields exactly one `rsp_valid` pulse, after which `req_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 16 | Local offset within the window |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data |
| map_cfg | input | 32 | Mapping word: [15:0] upper address half, [16] block |
| bus_num | input | 8 | Current bus number |
| cyc_valid | output | 1 | Configuration cycle request |
| cyc_ready | input | 1 | Bus engine acknowledge |
| cyc_addr | output | 32 | Type 0 configuration address |
| cyc_size | output | 2 | Cycle size code |
| cyc_write | output | 1 | Cycle direction |
| cyc_wdata | output | 32 | Cycle write data |
| cyc_rdata | input | 32 | Read data from the bus engine |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Response read data |
| rsp_err | output | 1 | Response carries an error |
| clr_abort | output | 1 | Clear received-abort status strobe |

## Verification
Two things always happen in the same cycle for a forwarded access: the response pulse and the clear-abort strobe. An error response, by contrast, must never carry that strobe. The bench provokes this by mixing forwarded, blocked, misaligned and empty-select accesses, and it varies the acknowledge latency at random. In each response cycle it judges three things together: `rsp_valid`, `rsp_err` and `clr_abort`, each against the class of access predicted by bench functions.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int CFG_W      = 32;
    localparam int HALF_W     = 16;
    localparam int IDSEL_LSB  = 11;
    localparam int IDSEL_W    = CFG_W - IDSEL_LSB;
    localparam int DEV_W      = $clog2(IDSEL_W);
    localparam int FUNC_LSB   = 8;
    localparam int FUNC_W     = 3;
    localparam int REG_LSB    = 2;
    localparam int REG_W      = 6;
    localparam int BUS_LSB    = 16;
    localparam int BLOCK_BIT  = 16;
    localparam int CFG_EN_BIT = 31;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        DEC_FWD   = 2'd0,
        DEC_BLOCK = 2'd1,
        DEC_ERR   = 2'd2
    } dec_kind_e;

    typedef struct packed {
        dec_kind_e           kind;
        logic [CFG_W-1:0]    addr;
    } dec_t;

    // index of lowest set bit; returns 0 for an all-zero field
    function automatic logic [DEV_W-1:0] lowest_set(input logic [IDSEL_W-1:0] v);
        logic [DEV_W-1:0] r;
        r = '0;
        for (int i = IDSEL_W - 1; i >= 0; i--) begin
            if (v[i]) r = DEV_W'(i);
        end
        return r;
    endfunction

    function automatic logic [CFG_W-1:0] ones_for(input acc_size_e s);
        case (s)
            SZ_BYTE: return CFG_W'(8'hFF);
            SZ_HALF: return CFG_W'(16'hFFFF);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic [HALF_W-1:0] laddr,
    input  acc_size_e         size,
    input  logic [CFG_W-1:0]  map_cfg,
    input  logic [BUS_W-1:0]  bus_num,
    output dec_t              dec
);
    logic [CFG_W-1:0]   word;
    logic [IDSEL_W-1:0] idsel;
    logic               misalign;

    always_comb begin
        word  = {map_cfg[HALF_W-1:0], laddr};
        idsel = word[CFG_W-1:IDSEL_LSB];
        unique case (size)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = laddr[0];
            SZ_WORD: misalign = |laddr[1:0];
            default: misalign = 1'b1;
        endcase

        dec.addr = '0;
        dec.addr[CFG_EN_BIT]                 = 1'b1;
        dec.addr[BUS_LSB +: BUS_W]           = bus_num;
        dec.addr[IDSEL_LSB +: DEV_W]         = lowest_set(idsel);
        dec.addr[FUNC_LSB +: FUNC_W]         = word[FUNC_LSB +: FUNC_W];
        dec.addr[REG_LSB +: REG_W]           = word[REG_LSB +: REG_W];

        if (misalign)                      dec.kind = DEC_ERR;
        else if (map_cfg[BLOCK_BIT])       dec.kind = DEC_BLOCK;
        else if (idsel == '0)              dec.kind = DEC_ERR;
        else                               dec.kind = DEC_FWD;
    end
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
    import cfgx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  acc_size_e         req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  dec_t              dec,
    output logic              cyc_valid,
    input  logic              cyc_ready,
    output logic [CFG_W-1:0]  cyc_addr,
    output acc_size_e         cyc_size,
    output logic              cyc_write,
    output logic [DATA_W-1:0] cyc_wdata,
    input  logic [DATA_W-1:0] cyc_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              clr_abort
);
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_RESP} state_e;

    typedef struct packed {
        logic [CFG_W-1:0]  addr;
        acc_size_e         size;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } cyc_t;

    state_e            st;
    cyc_t              cyc_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              fwd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cyc_q   <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
            fwd_q   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    cyc_q <= '{addr: dec.addr, size: req_size,
                               write: req_write, wdata: req_wdata};
                    if (dec.kind == DEC_FWD) begin
                        st      <= ST_ISSUE;
                        fwd_q   <= 1'b1;
                        err_q   <= 1'b0;
                        rdata_q <= '0;
                    end else begin
                        st      <= ST_RESP;
                        fwd_q   <= 1'b0;
                        err_q   <= (dec.kind == DEC_ERR);
                        rdata_q <= req_write ? '0 : DATA_W'(ones_for(req_size));
                    end
                end
                ST_ISSUE: if (cyc_ready) begin
                    st      <= ST_RESP;
                    rdata_q <= cyc_q.write ? '0 : cyc_rdata;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign cyc_valid = (st == ST_ISSUE);
    assign cyc_addr  = cyc_q.addr;
    assign cyc_size  = cyc_q.size;
    assign cyc_write = cyc_q.write;
    assign cyc_wdata = cyc_q.wdata;
    assign rsp_valid = (st == ST_RESP);
    assign rsp_rdata = rsp_valid ? rdata_q : '0;
    assign rsp_err   = rsp_valid && err_q;
    assign clr_abort = rsp_valid && fwd_q;

    // R5
    hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_valid && !cyc_ready |=> cyc_valid && $stable(cyc_addr) && $stable(cyc_wdata));
    // R5
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |-> !req_ready);
    // R6
    resp_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_valid && cyc_ready |=> rsp_valid && !rsp_err);
    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid && req_ready);
    // R7
    clr_only_ok_chk: assert property (@(posedge clk) disable iff (rst)
        clr_abort |-> rsp_valid && !rsp_err);
    // R2
    enable_bit_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |-> cyc_addr[CFG_EN_BIT]);
    // R8
    no_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && dec.kind != DEC_FWD |=> !cyc_valid && rsp_valid && !clr_abort);
endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator
    import cfgx_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [31:0]       map_cfg,
    input  logic [BUS_W-1:0]  bus_num,
    output logic              cyc_valid,
    input  logic              cyc_ready,
    output logic [31:0]       cyc_addr,
    output logic [1:0]        cyc_size,
    output logic              cyc_write,
    output logic [DATA_W-1:0] cyc_wdata,
    input  logic [DATA_W-1:0] cyc_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              clr_abort
);
    dec_t      dec;
    acc_size_e size_in;
    acc_size_e size_out;

    assign size_in  = acc_size_e'(req_size);
    assign cyc_size = size_out;

    cfgx_decode #(.BUS_W(BUS_W)) u_decode (
        .laddr   (req_addr),
        .size    (size_in),
        .map_cfg (map_cfg),
        .bus_num (bus_num),
        .dec     (dec)
    );

    cfgx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_size  (size_in),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .dec       (dec),
        .cyc_valid (cyc_valid),
        .cyc_ready (cyc_ready),
        .cyc_addr  (cyc_addr),
        .cyc_size  (size_out),
        .cyc_write (cyc_write),
        .cyc_wdata (cyc_wdata),
        .cyc_rdata (cyc_rdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .clr_abort (clr_abort)
    );
endmodule

// File: tb/test_cfgx_translator.sv
`timescale 1ns/1ps
module test_cfgx_translator;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] map_cfg = '0;
    logic [7:0]  bus_num = '0;
    logic        cyc_valid;
    logic        cyc_ready = 1'b0;
    logic [31:0] cyc_addr;
    logic [1:0]  cyc_size;
    logic        cyc_write;
    logic [31:0] cyc_wdata;
    logic [31:0] cyc_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        clr_abort;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    cfgx_translator i_cfgx_translator (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .map_cfg(map_cfg), .bus_num(bus_num),
        .cyc_valid(cyc_valid), .cyc_ready(cyc_ready), .cyc_addr(cyc_addr),
        .cyc_size(cyc_size), .cyc_write(cyc_write), .cyc_wdata(cyc_wdata),
        .cyc_rdata(cyc_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .clr_abort(clr_abort)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 0 forward, 1 blocked, 2 misaligned/bad size, 3 empty select
    function automatic int exp_kind(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] mp);
        bit bad;
        bad = (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'b00);
        if (bad) return 2;
        if (mp[16]) return 1;
        if ({mp[15:0], a[15:11]} == 21'd0) return 3;
        return 0;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [15:0] a, input logic [31:0] mp, input logic [7:0] bn);
        logic [31:0] w;
        int dev;
        w = {mp[15:0], a};
        dev = 0;
        for (int i = 20; i >= 0; i--) if (w[11 + i]) dev = i;
        return 32'h8000_0000 | (32'(bn) << 16) | (32'(dev) << 11) | (32'(w[10:8]) << 8) | (32'(w[7:2]) << 2);
    endfunction

    function automatic logic [31:0] ones_w(input logic [1:0] sz);
        case (sz)
            2'd0: return 32'hFF;
            2'd1: return 32'hFFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic run_acc(input logic [15:0] a, input logic [1:0] sz, input logic wr,
                           input logic [31:0] wd, input logic [31:0] mp,
                           input logic [7:0] bn, input int lat);
        int k;
        string tag;
        logic [31:0] ea, rd, er;
        k  = exp_kind(a, sz, mp);
        ea = exp_addr(a, mp, bn);
        tag = (k == 1) ? "R8" : (k == 2) ? "R10" : "R9";
        @(negedge clk);
        chk(req_ready, "R11 ready before request", 32'(req_ready), 32'd1);
        req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        map_cfg = mp; bus_num = bn; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (k == 0) begin
            chk(cyc_valid && !rsp_valid, "R5 cycle issued", 32'(cyc_valid), 32'd1);
            chk(cyc_addr == ea, "R2/R3 cycle address", cyc_addr, ea);
            chk(cyc_size == sz && cyc_write == wr, "R4 size and direction",
                {29'd0, cyc_size, cyc_write}, {29'd0, sz, wr});
            chk(cyc_wdata == wd, "R4 write data", cyc_wdata, wd);
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                chk(cyc_valid && !req_ready && cyc_addr == ea, "R5 held while waiting", cyc_addr, ea);
            end
            rd = $urandom;
            cyc_rdata = rd; cyc_ready = 1'b1;
            @(negedge clk);
            cyc_ready = 1'b0;
            er = wr ? 32'd0 : rd;
            chk(rsp_valid && !cyc_valid && !rsp_err, "R6 response after ack", 32'(rsp_valid), 32'd1);
            chk(rsp_rdata == er, "R6 response data", rsp_rdata, er);
            chk(clr_abort, "R7 strobe with forwarded response", 32'(clr_abort), 32'd1);
        end else begin
            er = wr ? 32'd0 : ones_w(sz);
            chk(!cyc_valid, {tag, " no cycle"}, 32'(cyc_valid), 32'd0);
            chk(rsp_valid && rsp_err == (k != 1), {tag, " response and error flag"},
                {30'd0, rsp_valid, rsp_err}, {30'd0, 1'b1, (k != 1)});
            chk(rsp_rdata == er, {tag, " read data"}, rsp_rdata, er);
            chk(!clr_abort, "R7 no strobe without cycle", 32'(clr_abort), 32'd0);
        end
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R11 single response", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        logic [31:0] mp;
        void'($urandom(32'd7));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(req_ready && !cyc_valid && !rsp_valid && !rsp_err && !clr_abort, "R1 reset state",
            {27'd0, req_ready, cyc_valid, rsp_valid, rsp_err, clr_abort}, 32'h10);
        // R3 select from mapping half: bit 21 -> device 10
        run_acc(16'h0534, 2'd2, 1'b0, 32'h0, 32'h0000_0020, 8'h03, 2);
        // R3 lowest of several select bits in the address half
        run_acc(16'hF800, 2'd0, 1'b1, 32'hA5, 32'h0000_FFFF, 8'h00, 0);
        run_acc(16'h2002, 2'd1, 1'b1, 32'h1234, 32'h0000_0000, 8'hFF, 1);
        // R8 blocked reads and write
        run_acc(16'h0800, 2'd0, 1'b0, 32'h0, 32'h0001_0000, 8'h01, 0);
        run_acc(16'h0802, 2'd1, 1'b0, 32'h0, 32'h0001_0000, 8'h01, 0);
        run_acc(16'h0804, 2'd2, 1'b0, 32'h0, 32'h0001_FFFF, 8'h01, 0);
        run_acc(16'h0804, 2'd2, 1'b1, 32'hDEAD, 32'h0001_0000, 8'h01, 0);
        // R9 empty select
        run_acc(16'h0004, 2'd2, 1'b0, 32'h0, 32'h0000_0000, 8'h02, 0);
        run_acc(16'h0001, 2'd0, 1'b1, 32'h5, 32'h0000_0000, 8'h02, 0);
        // R10 misaligned, bad size, precedence over R8
        run_acc(16'h0801, 2'd1, 1'b0, 32'h0, 32'h0000_0000, 8'h02, 0);
        run_acc(16'h0802, 2'd2, 1'b0, 32'h0, 32'h0001_0000, 8'h02, 0);
        run_acc(16'h0800, 2'd3, 1'b0, 32'h0, 32'h0000_0000, 8'h02, 0);
        // random mix
        for (int n = 0; n < 400; n++) begin
            a  = 16'($urandom);
            mp = $urandom & 32'h0001_FFFF;
            if ($urandom_range(0, 5) != 0) mp[16] = 1'b0;
            if ($urandom_range(0, 6) == 0) begin mp[15:0] = '0; a[15:11] = '0; end
            if ($urandom_range(0, 2) != 0) a[1:0] = 2'b00;
            run_acc(a, 2'($urandom_range(0, 3)), 1'($urandom), $urandom, mp,
                    8'($urandom), int'($urandom_range(0, 3)));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule